// File: doc/BRIEF.md
# Line-Rate Doubler for Low-Resolution RGB Video

This block takes a low-resolution RGB stream with its horizontal and vertical sync and produces a stream at twice the line rate, so it can drive a display that needs a higher horizontal frequency. Everything runs on one master clock. The block derives enables from that clock and never generates a divided clock. Each incoming line is captured at one pixel per four master clocks into one bank of a two-bank line store. The line before it is played out of the other bank twice, at one pixel per two master clocks.

The output line timing comes from a phase counter that wraps every half input line. That counter is aligned to the incoming horizontal sync only once: at the first sync edge after reset, or at the first one after the block has seen an input line of the wrong length. On every other input line it runs freely. Because of this, successive output sync pulses keep the same spacing and the same phase. The output sync pulse is half as wide as the input pulse. Output vertical sync changes only at the start of an output line and is held for whole lines. Pixel data reads as zero whenever either output sync is active.

Top module: `scan_doubler`

## Requirements
- R1: The first clock edge at which `hs_in` is high after being low is the line start. It moves capture to the other bank and drops any pixel due at that edge. Pixel k of the line (k = 0, 1, ...) is the `pix_in` value sampled 4*(k+1) clocks after the line start.
- R2: Let p be the output phase, with p = 0 in the cycle after an output line starts. In an unblanked cycle with p >= 2, `pix_out` equals pixel (p-2)/2, rounded down, of the most recently completed input line. That line is shown in both output lines that follow it.
- R3: Output lines last exactly 1710 master clocks. Between two phase alignments, rising edges of `hs_out` are exactly 1710 clocks apart.
- R4: While locked, an input line start does not move the output phase. If the input line that just ended did not last exactly 3420 clocks, lock is lost and the phase still continues undisturbed.
- R5: The first input line start after reset, or after lock is lost, aligns the output phase. From the next cycle p = 0 and `hs_out` is 1.
- R6: `hs_out` is 1 exactly when p < H. H is half the number of clocks `hs_in` was last sampled high, rounded down, and takes effect from the edge at which `hs_in` is first sampled low. H is 64 after reset.
- R7: `vs_out` changes only at an output line start. It is then 1 for the whole line if `vs_in` was sampled high at any edge of the previous output line, counting the edge that starts the new line.
- R8: `pix_out` is zero in every cycle in which `hs_out` or `vs_out` is 1.
- R9: While `rst` is high, `pix_out`, `hs_out` and `vs_out` are 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 12 | Incoming RGB pixel, 4 bits per colour |
| hs_in | input | 1 | Incoming horizontal sync, active high |
| vs_in | input | 1 | Incoming vertical sync, active high |
| pix_out | output | 12 | Doubled-rate RGB pixel, zero while blanked |
| hs_out | output | 1 | Regenerated horizontal sync at twice the line rate |
| vs_out | output | 1 | Vertical sync aligned to output line starts |

## Verification
The hardest case to reach is loss of lock. Lock drops at a line start without moving the phase, and the block realigns only at the line start after that. A block that resynchronises on every sync edge looks correct whenever the input lines are exactly 3420 clocks long. The stimulus therefore runs several regular lines, then a 3000-clock line, then regular lines again. This checks that the spacing of `hs_out` stays at 1710 clocks across the short line's end, and that the jump happens only one input line later. The sync width is also changed after the short line. A short vertical pulse of one clock is sent to show that the output stretches it to a whole line.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int unsigned PIX_W = 12;
  typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/sd_in_side.sv
// Capture side: sync edge detection, input enable, write addressing,
// line length and sync width measurement.
module sd_in_side
  import sd_pkg::*;
#(
  parameter int unsigned LINE_CLKS = 3420,
  parameter int unsigned CE_IN_DIV = 4,
  parameter int unsigned DEPTH     = 1024,
  parameter int unsigned HSW_RST   = 64,
  parameter int unsigned AW        = $clog2(DEPTH),
  parameter int unsigned LEN_W     = $clog2(LINE_CLKS + 1) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_in,
  output logic             hs_rise,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             wr_bank,
  output logic             len_ok,
  output logic [LEN_W-1:0] hs_half
);
  localparam int unsigned CW = (CE_IN_DIV > 1) ? $clog2(CE_IN_DIV) : 1;
  localparam logic [CW-1:0]    CE_LAST   = CW'(CE_IN_DIV - 1);
  localparam logic [LEN_W-1:0] LEN_REF   = LEN_W'(LINE_CLKS);
  localparam logic [LEN_W-1:0] LEN_MAX   = '1;
  localparam logic [AW-1:0]    ADDR_LAST = AW'(DEPTH - 1);

  logic             hs_q;
  logic             hs_fall;
  logic [CW-1:0]    cin;
  logic [LEN_W-1:0] len_cnt;
  logic [LEN_W-1:0] hw_cnt;

  assign hs_rise = hs_in & ~hs_q;
  assign hs_fall = ~hs_in & hs_q;
  assign wr_en   = (cin == CE_LAST) && !hs_rise;
  assign len_ok  = (len_cnt == LEN_REF);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q    <= 1'b0;
      cin     <= '0;
      len_cnt <= '0;
      hw_cnt  <= '0;
      wr_addr <= '0;
      wr_bank <= 1'b0;
      hs_half <= LEN_W'(HSW_RST);
    end else begin
      hs_q <= hs_in;
      if (hs_rise) begin
        cin     <= '0;
        len_cnt <= LEN_W'(1);
        hw_cnt  <= LEN_W'(1);
        wr_addr <= '0;
        wr_bank <= ~wr_bank;
      end else begin
        cin <= (cin == CE_LAST) ? '0 : cin + 1'b1;
        if (len_cnt != LEN_MAX) len_cnt <= len_cnt + 1'b1;
        if (hs_in && hw_cnt != LEN_MAX) hw_cnt <= hw_cnt + 1'b1;
        if (wr_en && wr_addr != ADDR_LAST) wr_addr <= wr_addr + 1'b1;
      end
      if (hs_fall) hs_half <= hw_cnt >> 1;
    end
  end
endmodule

// File: rtl/sd_line_buf.sv
// Two-bank line store, one write port and one registered read port,
// shaped for block RAM inference.
module sd_line_buf
  import sd_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  pix_t          wdata,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output pix_t          rdata
);
  pix_t mem [0:2*DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[{wbank, waddr}] <= wdata;
    rdata <= mem[{rbank, raddr}];
  end
endmodule

// File: rtl/sd_out_timing.sv
// Output timing: free-running phase with one-shot alignment,
// read addressing, sync regeneration and blanking decision.
module sd_out_timing #(
  parameter int unsigned LINE_OUT = 1710,
  parameter int unsigned DEPTH    = 1024,
  parameter int unsigned AW       = $clog2(DEPTH),
  parameter int unsigned LEN_W    = 13,
  parameter int unsigned PH_W     = $clog2(LINE_OUT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_rise,
  input  logic             len_ok,
  input  logic [LEN_W-1:0] hs_half,
  input  logic             vs_in,
  output logic [PH_W-1:0]  phase,
  output logic             locked,
  output logic [AW-1:0]    rd_addr,
  output logic             hs_out,
  output logic             vs_out,
  output logic             blank_nxt
);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(LINE_OUT - 1);
  localparam logic [AW-1:0]   ADDR_LAST = AW'(DEPTH - 1);

  logic            align;
  logic [PH_W-1:0] phase_nxt;
  logic            line_start;
  logic            out_ce;
  logic            hs_nxt;
  logic            vs_nxt;
  logic            vs_seen;

  assign align      = hs_rise && !locked;
  assign phase_nxt  = (align || phase == PH_LAST) ? '0 : phase + 1'b1;
  assign line_start = (phase_nxt == '0);
  assign out_ce     = phase[0];
  assign hs_nxt     = (LEN_W'(phase_nxt) < hs_half);
  assign vs_nxt     = line_start ? (vs_seen | vs_in) : vs_out;
  assign blank_nxt  = hs_nxt | vs_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      locked  <= 1'b0;
      rd_addr <= '0;
      hs_out  <= 1'b0;
      vs_out  <= 1'b0;
      vs_seen <= 1'b0;
    end else begin
      phase  <= phase_nxt;
      hs_out <= hs_nxt;
      vs_out <= vs_nxt;
      vs_seen <= line_start ? 1'b0 : (vs_seen | vs_in);
      if (hs_rise) begin
        if (!locked)     locked <= 1'b1;
        else if (!len_ok) locked <= 1'b0;
      end
      if (line_start)                         rd_addr <= '0;
      else if (out_ce && rd_addr != ADDR_LAST) rd_addr <= rd_addr + 1'b1;
    end
  end
endmodule

// File: rtl/scan_doubler.sv
module scan_doubler
  import sd_pkg::*;
#(
  parameter int unsigned LINE_CLKS = 3420,
  parameter int unsigned CE_IN_DIV = 4,
  parameter int unsigned DEPTH     = 1024,
  parameter int unsigned HSW_RST   = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             hs_in,
  input  logic             vs_in,
  output logic [PIX_W-1:0] pix_out,
  output logic             hs_out,
  output logic             vs_out
);
  localparam int unsigned LINE_OUT = LINE_CLKS / 2;
  localparam int unsigned AW       = $clog2(DEPTH);
  localparam int unsigned LEN_W    = $clog2(LINE_CLKS + 1) + 1;
  localparam int unsigned PH_W     = $clog2(LINE_OUT);

  logic             hs_rise;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic             wr_bank;
  logic             len_ok;
  logic [LEN_W-1:0] hs_half;
  logic [PH_W-1:0]  phase;
  logic             locked;
  logic [AW-1:0]    rd_addr;
  logic             blank_nxt;
  pix_t             rd_data;

  sd_in_side #(
    .LINE_CLKS(LINE_CLKS), .CE_IN_DIV(CE_IN_DIV), .DEPTH(DEPTH),
    .HSW_RST(HSW_RST), .AW(AW), .LEN_W(LEN_W)
  ) in_i (
    .clk(clk), .rst(rst), .hs_in(hs_in), .hs_rise(hs_rise),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bank(wr_bank),
    .len_ok(len_ok), .hs_half(hs_half)
  );

  sd_line_buf #(.DEPTH(DEPTH), .AW(AW)) buf_i (
    .clk(clk), .we(wr_en), .wbank(wr_bank), .waddr(wr_addr), .wdata(pix_in),
    .rbank(~wr_bank), .raddr(rd_addr), .rdata(rd_data)
  );

  sd_out_timing #(
    .LINE_OUT(LINE_OUT), .DEPTH(DEPTH), .AW(AW), .LEN_W(LEN_W), .PH_W(PH_W)
  ) tim_i (
    .clk(clk), .rst(rst), .hs_rise(hs_rise), .len_ok(len_ok),
    .hs_half(hs_half), .vs_in(vs_in), .phase(phase), .locked(locked),
    .rd_addr(rd_addr), .hs_out(hs_out), .vs_out(vs_out), .blank_nxt(blank_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) pix_out <= '0;
    else     pix_out <= blank_nxt ? '0 : rd_data;
  end
endmodule

// File: rtl/sd_chk.sv
module sd_chk #(
  parameter int unsigned LINE_OUT = 1710,
  parameter int unsigned PH_W     = 11,
  parameter int unsigned PIX_W    = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             hs_out,
  input logic             vs_out,
  input logic [PIX_W-1:0] pix_out,
  input logic [PH_W-1:0]  phase,
  input logic             locked,
  input logic             hs_rise
);
  localparam int unsigned GW = PH_W + 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(LINE_OUT - 1);
  localparam logic [GW-1:0]   GAP_REF = GW'(LINE_OUT);

  logic [GW-1:0]   gap;
  logic            hs_q, seen, moved;
  logic [PH_W-1:0] phase_succ;

  assign phase_succ = (phase == PH_LAST) ? '0 : phase + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0; hs_q <= 1'b0; seen <= 1'b0; moved <= 1'b0;
    end else begin
      hs_q <= hs_out;
      if (hs_out && !hs_q) begin
        gap <= GW'(1); seen <= 1'b1; moved <= 1'b0;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
      if (hs_rise && !locked) moved <= 1'b1;
    end
  end

  // R3
  hs_period_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hs_out) && seen && !moved) |-> (gap == GAP_REF));

  // R4
  no_resync_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_rise && locked) |=> (phase == $past(phase_succ)));

  // R7
  vs_align_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(vs_out) |-> (phase == '0));

  // R8
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_out || vs_out) |-> (pix_out == '0));

  // R9
  reset_chk: assert property (@(posedge clk)
    rst |=> (pix_out == '0 && !hs_out && !vs_out));
endmodule

bind scan_doubler sd_chk #(.LINE_OUT(LINE_OUT), .PH_W(PH_W), .PIX_W(sd_pkg::PIX_W)) chk_i (
  .clk(clk), .rst(rst), .hs_out(hs_out), .vs_out(vs_out), .pix_out(pix_out),
  .phase(phase), .locked(locked), .hs_rise(hs_rise)
);

// File: tb/scan_doubler_tb_top.sv
module scan_doubler_tb_top;
  localparam int LCLK = 3420;
  localparam int LOUT = 1710;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] pix_d = '0;
  logic        hs_d = 1'b0;
  logic        vs_d = 1'b0;
  logic [11:0] pix_out;
  logic        hs_out, vs_out;

  always #4 clk = ~clk;

  scan_doubler dut_i (
    .clk(clk), .rst(rst), .pix_in(pix_d), .hs_in(hs_d), .vs_in(vs_d),
    .pix_out(pix_out), .hs_out(hs_out), .vs_out(vs_out)
  );

  int errs = 0, checks = 0;
  bit done = 0;

  function automatic logic [11:0] pv(int l, int k);
    return 12'((l * 97 + k * 13 + 5) % 4096);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected behaviour derived from the requirements, cycle by cycle
  int m_phase, m_len, m_hw, m_hsw, m_cur, m_rdl;
  bit m_hsq, m_locked, m_flag, m_vseen, m_vs;
  bit e_hs, e_vs, e_blank, e_pchk, e_realign, e_lockrise;
  logic [11:0] e_pix;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_len = 0; m_hw = 0; m_hsw = 64; m_cur = -1; m_rdl = -1;
      m_hsq = 0; m_locked = 0; m_flag = 0; m_vseen = 0; m_vs = 0;
      e_hs = 0; e_vs = 0; e_blank = 1; e_pchk = 0; e_realign = 0; e_lockrise = 0;
      e_pix = '0;
    end else begin
      bit rise, fall, ls, nvs;
      int pn;
      rise = hs_d && !m_hsq;
      fall = !hs_d && m_hsq;
      e_realign  = rise && !m_locked;
      e_lockrise = rise && m_locked;
      pn = (e_realign || m_phase == LOUT - 1) ? 0 : m_phase + 1;
      ls = (pn == 0);
      if (rise) begin
        if (!m_locked) m_locked = 1;
        else if (m_len != LCLK) m_locked = 0;
        m_flag = (m_cur >= 0) && (m_len == LCLK);
        m_rdl = m_cur;
        m_cur++;
      end
      m_len = rise ? 1 : m_len + 1;
      e_hs = (pn < m_hsw);
      if (fall) m_hsw = m_hw / 2;
      m_hw = rise ? 1 : (hs_d ? m_hw + 1 : m_hw);
      nvs = ls ? (m_vseen || vs_d) : m_vs;
      m_vseen = ls ? 0 : (m_vseen || vs_d);
      m_vs = nvs; e_vs = nvs;
      e_blank = e_hs || e_vs;
      e_pchk = !e_blank && m_flag && (pn >= 2);
      e_pix = pv(m_rdl, (pn - 2) / 2);
      m_phase = pn;
      m_hsq = hs_d;
    end
  end

  // hsync spacing tracking
  int cyc = 0, last_rise = 0;
  bit prev_ok = 0, moved = 0, hs_prev = 0;

  task automatic observe();
    if (e_realign) chk(hs_out == 1'b1, "R5 hs_out after align", hs_out, 1);
    else if (e_lockrise) chk(hs_out == e_hs, "R4 hs_out at locked line start", hs_out, e_hs);
    else chk(hs_out == e_hs, "R6 hs_out width", hs_out, e_hs);
    chk(vs_out == e_vs, "R7 vs_out", vs_out, e_vs);
    if (e_blank) chk(pix_out == 12'h000, "R8 blanking", pix_out, 0);
    else if (e_pchk) chk(pix_out == e_pix, "R1 R2 pixel", pix_out, e_pix);
    if (e_realign) moved = 1;
    if (hs_out && !hs_prev) begin
      if (prev_ok && !moved) chk(cyc - last_rise == LOUT, "R3 hs period", cyc - last_rise, LOUT);
      prev_ok = 1; moved = 0; last_rise = cyc;
    end
    hs_prev = hs_out;
    cyc++;
  endtask

  int lens [7] = '{3420, 3420, 3420, 3000, 3420, 3420, 3420};
  int wids [7] = '{40, 40, 40, 40, 60, 60, 60};

  initial begin
    repeat (3) @(negedge clk);
    chk(pix_out == 12'h000, "R9 reset pix_out", pix_out, 0);
    chk(hs_out == 1'b0, "R9 reset hs_out", hs_out, 0);
    chk(vs_out == 1'b0, "R9 reset vs_out", vs_out, 0);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      observe();
    end
    for (int l = 0; l < 7; l++) begin
      for (int n = 0; n < lens[l]; n++) begin
        @(negedge clk);
        observe();
        hs_d  = (n < wids[l]);
        vs_d  = (l == 5 && n >= 500 && n < 520) || (l == 6 && n == 1000);
        pix_d = (n >= 4) ? pv(l, (n - 4) / 4) : 12'h000;
      end
    end
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      observe();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule